// File: doc/BRIEF.md
# Segmented DAC Input Decoder

This block is the digital front end of a segmented current-steering digital-to-analog converter. Each clock cycle it captures an 8-bit parallel word together with an invert control, places the (optionally inverted) word in the top of a 10-bit internal code whose two lowest bits are held at zero, and splits that code in two. The upper 4 bits become 15 unary (thermometer) enable lines, one per equal-weight current segment. The lower 6 bits go out unchanged as binary-weighted switch controls.

Every switch-control line leaves the block from a single output register, so all 21 lines change on the same clock edge and unequal decode delays never reach the current switches. A new word may be presented every cycle; there is no handshake and no back-pressure, because the converter consumes one sample per clock without exception. The result of a word appears on the outputs two clock edges after it is presented.

Top module: `sdac_frontend`

## Requirements
- R1: A synchronous active-high reset clears the capture and output registers; while reset is sampled high, and for the first edge after it is released, every segment enable and every binary control is 0.
- R2: The outputs reflect the word and invert control sampled two rising edges earlier (one edge for capture, one for the output register).
- R3: For an upper code value n (internal code bits 9..6), segment enables 0 through n-1 are 1 and all others 0: value 0 gives no line on, value 15 gives all 15 lines on.
- R4: Binary control bit i equals internal code bit i for i = 0..5, carrying weight 2^i with no decoding.
- R5: The internal code is the captured 8-bit word in bits 9..2 with bits 1..0 at zero, so binary controls 1..0 are always 0.
- R6: When the invert control is 1, all 8 data bits are inverted before decoding; when it is 0 they pass unchanged. The two zero-padded bits are never inverted.
- R7: With word and invert control held constant, the outputs do not change; all 21 lines update only on a rising clock edge.
- R8: A different word on every consecutive cycle produces a matching result on every consecutive cycle (full throughput of one word per clock).
- R9: For every input, the number of active segment enables times 64 plus the binary control value equals the expected 10-bit code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | 8 | Input word, bit 7 most significant |
| invert_en | input | 1 | Active-high invert control for the input word |
| seg_on | output | 15 | Thermometer-coded segment enables, bit 0 first to turn on |
| bin_ctl | output | 6 | Binary-weighted switch controls, bit i of weight 2^i |

## Verification
The checker takes for granted that the word and invert control are known (no X or Z) at every rising edge once reset has been released, and that reset is asserted from time zero so its history counter starts from a defined value. The stimulus changes inputs only on falling edges, drives every word as a defined value, sweeps all 256 words under both invert settings back to back, adds seeded random words with random invert settings, and holds reset high from the start, later pulsing it in the middle of running traffic.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  // Number of unary lines for an upper segment of the given bit width.
  function automatic int unsigned unary_lines(input int unsigned seg_bits);
    return (32'd1 << seg_bits) - 32'd1;
  endfunction

  // Width of the zero padding below the input word inside the internal code.
  function automatic int unsigned pad_bits(input int unsigned code_bits,
                                           input int unsigned word_bits);
    return (code_bits > word_bits) ? (code_bits - word_bits) : 0;
  endfunction

endpackage

// File: rtl/sdac_capture.sv
module sdac_capture #(
  parameter int IN_W   = 8,
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IN_W-1:0]   word_i,
  input  logic              invert_i,
  output logic [CODE_W-1:0] code_o
);
  import sdac_pkg::*;

  localparam int PAD_W = pad_bits(CODE_W, IN_W);

  logic [IN_W-1:0]   word_eff;
  logic [CODE_W-1:0] code_d;

  // Invert applies to the data bits only.
  assign word_eff = word_i ^ {IN_W{invert_i}};

  generate
    if (PAD_W > 0) begin : g_pad
      assign code_d = {word_eff, {PAD_W{1'b0}}};
    end else begin : g_trunc
      assign code_d = word_eff[IN_W-1 -: CODE_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) code_o <= '0;
    else     code_o <= code_d;
  end

endmodule

// File: rtl/sdac_therm.sv
module sdac_therm #(
  parameter int SEG_W = 4,
  parameter int SEG_N = 15
) (
  input  logic [SEG_W-1:0] seg_val_i,
  output logic [SEG_N-1:0] lines_o
);

  // Line i is on when the segment value exceeds i: lines fill from bit 0.
  generate
    for (genvar i = 0; i < SEG_N; i++) begin : g_line
      assign lines_o[i] = (seg_val_i > SEG_W'(i));
    end
  endgenerate

endmodule

// File: rtl/sdac_outreg.sv
module sdac_outreg #(
  parameter int SEG_N = 15,
  parameter int LSB_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEG_N-1:0] seg_d,
  input  logic [LSB_W-1:0] bin_d,
  output logic [SEG_N-1:0] seg_q,
  output logic [LSB_W-1:0] bin_q
);

  // One register for every switch line so all change on the same edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q <= '0;
      bin_q <= '0;
    end else begin
      seg_q <= seg_d;
      bin_q <= bin_d;
    end
  end

endmodule

// File: rtl/sdac_frontend.sv
module sdac_frontend #(
  parameter  int IN_W   = 8,
  parameter  int CODE_W = 10,
  parameter  int LSB_W  = 6,
  localparam int SEG_W  = CODE_W - LSB_W,
  localparam int SEG_N  = (1 << SEG_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IN_W-1:0]  data_in,
  input  logic             invert_en,
  output logic [SEG_N-1:0] seg_on,
  output logic [LSB_W-1:0] bin_ctl
);

  logic [CODE_W-1:0] code_q;
  logic [SEG_N-1:0]  seg_lines;

  sdac_capture #(
    .IN_W   (IN_W),
    .CODE_W (CODE_W)
  ) u_capture (
    .clk      (clk),
    .rst      (rst),
    .word_i   (data_in),
    .invert_i (invert_en),
    .code_o   (code_q)
  );

  sdac_therm #(
    .SEG_W (SEG_W),
    .SEG_N (SEG_N)
  ) u_therm (
    .seg_val_i (code_q[CODE_W-1:LSB_W]),
    .lines_o   (seg_lines)
  );

  sdac_outreg #(
    .SEG_N (SEG_N),
    .LSB_W (LSB_W)
  ) u_outreg (
    .clk   (clk),
    .rst   (rst),
    .seg_d (seg_lines),
    .bin_d (code_q[LSB_W-1:0]),
    .seg_q (seg_on),
    .bin_q (bin_ctl)
  );

endmodule

// File: rtl/sdac_frontend_chk.sv
module sdac_frontend_chk #(
  parameter int IN_W   = 8,
  parameter int CODE_W = 10,
  parameter int LSB_W  = 6,
  parameter int SEG_N  = 15
) (
  input logic             clk,
  input logic             rst,
  input logic [IN_W-1:0]  data_in,
  input logic             invert_en,
  input logic [SEG_N-1:0] seg_on,
  input logic [LSB_W-1:0] bin_ctl
);
  import sdac_pkg::*;

  localparam int PAD_W = pad_bits(CODE_W, IN_W);

  // Edges seen with reset low, saturating at 3.
  logic [1:0] seen;
  always_ff @(posedge clk) begin
    if (rst)               seen <= 2'd0;
    else if (seen != 2'd3) seen <= seen + 2'd1;
  end

  logic [CODE_W-1:0] sum_now;
  assign sum_now = (CODE_W'($countones(seg_on)) << LSB_W) | CODE_W'(bin_ctl);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    (seen < 2'd2) |-> (seg_on == '0 && bin_ctl == '0));

  assert_unary_fill_R3: assert property (@(posedge clk) disable iff (rst)
    ((seg_on + SEG_N'(1)) & seg_on) == '0);

  assert_pad_zero_R5: assert property (@(posedge clk) disable iff (rst)
    bin_ctl[1:0] == 2'b00);

  // R2, R6, R9: weighted sum of outputs matches the word from two edges back.
  assert_code_match_R9: assert property (@(posedge clk) disable iff (rst)
    (seen >= 2'd2) |->
      (sum_now == CODE_W'({($past(data_in, 2) ^ {IN_W{$past(invert_en, 2)}}),
                           {PAD_W{1'b0}}})));

  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (seen == 2'd3 && $past(data_in, 2) == $past(data_in, 3)
                  && $past(invert_en, 2) == $past(invert_en, 3))
      |-> ($stable(seg_on) && $stable(bin_ctl)));

endmodule

bind sdac_frontend sdac_frontend_chk #(
  .IN_W   (IN_W),
  .CODE_W (CODE_W),
  .LSB_W  (LSB_W),
  .SEG_N  (SEG_N)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .data_in   (data_in),
  .invert_en (invert_en),
  .seg_on    (seg_on),
  .bin_ctl   (bin_ctl)
);

// File: tb/sdac_frontend_test.sv
module sdac_frontend_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  data_in = 8'h00;
  logic        invert_en = 1'b0;
  logic [14:0] seg_on;
  logic [5:0]  bin_ctl;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // pipeline history in the bench: word driven one and two falling edges ago
  logic [7:0] h0_w, h1_w;
  logic       h0_c, h1_c;
  int         hist = 0;

  always #2.5 clk = ~clk;

  sdac_frontend uut (
    .clk       (clk),
    .rst       (rst),
    .data_in   (data_in),
    .invert_en (invert_en),
    .seg_on    (seg_on),
    .bin_ctl   (bin_ctl)
  );

  function automatic logic [9:0] exp_code(input logic [7:0] w, input logic c);
    return {w ^ {8{c}}, 2'b00};
  endfunction

  function automatic logic [14:0] exp_seg(input logic [7:0] w, input logic c);
    logic [9:0] k;
    k = exp_code(w, c);
    return 15'((16'd1 << k[9:6]) - 16'd1);
  endfunction

  function automatic logic [5:0] exp_bin(input logic [7:0] w, input logic c);
    logic [9:0] k;
    k = exp_code(w, c);
    return k[5:0];
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  // compare outputs against the word driven two falling edges ago
  task automatic check_out(input string tag);
    logic [9:0] s;
    s = 10'(($countones(seg_on) * 64) + int'(bin_ctl));
    check(seg_on == exp_seg(h1_w, h1_c), {tag, " R3 seg"}, int'(seg_on), int'(exp_seg(h1_w, h1_c)));
    check(bin_ctl == exp_bin(h1_w, h1_c), {tag, " R4 bin"}, int'(bin_ctl), int'(exp_bin(h1_w, h1_c)));
    check(s == exp_code(h1_w, h1_c), {tag, " R9 sum"}, int'(s), int'(exp_code(h1_w, h1_c)));
  endtask

  // one falling-edge step: check due result, then drive the next word
  task automatic step(input logic [7:0] w, input logic c, input string tag);
    @(negedge clk);
    if (hist >= 2) check_out(tag);
    h1_w = h0_w; h1_c = h0_c;
    h0_w = w;    h0_c = c;
    data_in   = w;
    invert_en = c;
    hist++;
  endtask

  initial begin
    #(5ns * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [14:0] hold_seg;
    logic [5:0]  hold_bin;
    void'($urandom(32'd1234));

    // R1: reset from time zero with busy inputs
    data_in = 8'hFF; invert_en = 1'b0;
    repeat (3) @(negedge clk);
    check(seg_on == '0, "R1 reset seg", int'(seg_on), 0);
    check(bin_ctl == '0, "R1 reset bin", int'(bin_ctl), 0);

    // release; first edge after release still shows cleared state
    hist = 0;
    h0_w = 8'h00; h0_c = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    data_in = 8'hFF; invert_en = 1'b0; h0_w = 8'hFF; h0_c = 1'b0; hist = 1;
    @(negedge clk);
    check(seg_on == '0 && bin_ctl == '0, "R1 first edge after release",
          int'({seg_on, bin_ctl}), 0);
    h1_w = h0_w; h1_c = h0_c;
    data_in = 8'h00; h0_w = 8'h00; h0_c = 1'b0; hist = 2;
    // R2: result of 0xFF appears exactly two edges after presentation
    @(negedge clk);
    check(seg_on == 15'h7FFF && bin_ctl == 6'h3C, "R2 latency two edges",
          int'({seg_on, bin_ctl}), int'({15'h7FFF, 6'h3C}));
    h1_w = h0_w; h1_c = h0_c;

    // directed corners: R3 all-off / all-on, R5 pad zero, R6 invert
    step(8'h00, 1'b0, "R3 zero");
    step(8'hFF, 1'b0, "R3 full");
    step(8'h00, 1'b1, "R6 invert of zero");
    step(8'hFF, 1'b1, "R6 invert of full");
    step(8'h0F, 1'b0, "R4 low only");
    step(8'hF0, 1'b1, "R6 R4 inverted upper");
    step(8'h10, 1'b0, "R3 one segment");
    step(8'h7F, 1'b0, "R5 pad");

    // R8: all 256 words back to back in both invert settings
    for (int c = 0; c < 2; c++)
      for (int w = 0; w < 256; w++)
        step(8'(w), 1'(c), "R8 sweep");

    // seeded random words with random invert
    for (int i = 0; i < 1500; i++)
      step(8'($urandom), 1'($urandom), "R6 random");

    // R7: hold a word, outputs must not move
    for (int i = 0; i < 3; i++) step(8'hA5, 1'b0, "R7 hold");
    hold_seg = seg_on; hold_bin = bin_ctl;
    for (int i = 0; i < 4; i++) begin
      step(8'hA5, 1'b0, "R7 hold");
      check(seg_on == hold_seg && bin_ctl == hold_bin, "R7 stable",
            int'({seg_on, bin_ctl}), int'({hold_seg, hold_bin}));
      @(posedge clk); #1;
      check(seg_on == hold_seg && bin_ctl == hold_bin, "R7 stable after edge",
            int'({seg_on, bin_ctl}), int'({hold_seg, hold_bin}));
    end

    // R1: reset during running traffic
    @(negedge clk);
    rst = 1'b1; data_in = 8'hC3; invert_en = 1'b0;
    @(negedge clk);
    check(seg_on == '0 && bin_ctl == '0, "R1 mid-stream reset",
          int'({seg_on, bin_ctl}), 0);
    rst = 1'b0; data_in = 8'h5A; invert_en = 1'b1;
    h0_w = 8'h5A; h0_c = 1'b1; hist = 1;
    @(negedge clk);
    check(seg_on == '0 && bin_ctl == '0, "R1 edge after mid reset",
          int'({seg_on, bin_ctl}), 0);
    h1_w = h0_w; h1_c = h0_c;
    data_in = 8'h3C; invert_en = 1'b0; h0_w = 8'h3C; h0_c = 1'b0; hist = 2;
    step(8'h81, 1'b0, "R2 restart");
    step(8'h81, 1'b0, "R2 restart");
    step(8'h81, 1'b0, "R2 restart");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule